// File: doc/BRIEF.md
# Message Object Interface Transfer Unit

This unit sits between a CPU register bus and a bank of message objects. Software fills a small set of staging registers: the mask, the arbitration word, the control word, two data words and a command word. It then writes an object number, and that write starts a transfer. The command word sets the direction of the transfer. A write transfer copies the selected staging registers into the object. A read transfer copies the selected object fields back into the staging registers. The same command word can also operate on the object's status flags. A read can clear the interrupt-pending flag and the new-data flag. A write can raise the transmit-request flag.

Each transfer spends a fixed window of clock cycles on the object storage. A busy flag in the status register covers this window, and software polls it before it touches the staging set again. The bus has no back-pressure. A write is taken in the cycle it is presented. While the unit is busy, every bus write is discarded, so polling the busy bit is the only flow control. Reads are combinational and always allowed. The interrupt-pending flag of every object drives one output bit, so a downstream interrupt controller can see which object is pending.

Top module: `mif_xfer_unit`

## Requirements
- R1: After reset, every staging register, the command register, the number register and the status register read 0, every object field is 0 and `obj_irq` is all zero.
- R2: Register addresses on `bus_addr` are 0 command, 1 mask, 2 arbitration, 3 control, 4 data A, 5 data B, 6 object number and 7 status, which is read-only. Writing a number from 1 to 64 to address 6 while idle sets status bit 7 (busy) from the next cycle for exactly 4 cycles. The transfer then takes effect on object number minus one, and number 64 is valid.
- R3: Writing 0, or any value above 64, to address 6 starts no transfer, leaves busy at 0 and leaves the number register unchanged.
- R4: When command bit 23 is 1 (write direction), each object field whose select bit is 1 takes the staging value. The select bits are: command bit 7 for mask, bit 6 for arbitration, bit 5 for control, bit 1 for data A and bit 0 for data B. Fields whose select bit is 0 keep their value.
- R5: When command bit 23 is 0 (read direction), each selected staging register takes the object field. Staging registers that are not selected keep their value.
- R6: A read with command bit 3 set clears the object's interrupt-pending flag (control bit 13). A staging control register that is selected receives the control word as it was before the clear.
- R7: A write with command bit 3 set leaves the object's interrupt-pending flag unchanged, unless the control field itself is selected.
- R8: A read with command bit 2 set clears the object's new-data flag (control bit 15).
- R9: A write with command bit 2 set sets the object's transmit-request flag (control bit 8). This takes effect after the selected control value has been written.
- R10: While busy, bus writes to any address, including the number register, are ignored. No second transfer follows.
- R11: `obj_irq[k]` equals control bit 13 of object number k+1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, accepted every cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| obj_irq | output | 64 | Interrupt-pending flag of each object |

## Verification
A wrong access counter shows at once as a busy window shorter or longer than four cycles on status bit 7. A wrong field select or a mis-decoded object index does not show at the moment it happens. It is hidden in the storage and appears only on a later read transfer of that object, through the staging registers, or at once on `obj_irq` when the control word is involved. Flag operations that use the wrong direction corrupt `obj_irq` on the cycle after the access window closes. For this reason every transfer in the bench is followed by a comparison of the staging registers and the full interrupt vector.

// File: rtl/mif_pkg.sv
package mif_pkg;
  // bus register addresses
  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_MASK = 3'd1;
  localparam logic [2:0] A_ARB  = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_DA   = 3'd4;
  localparam logic [2:0] A_DB   = 3'd5;
  localparam logic [2:0] A_NUM  = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  // field slots, staging address = slot + 1
  localparam int NFLD   = 5;
  localparam int F_MASK = 0;
  localparam int F_ARB  = 1;
  localparam int F_CTRL = 2;
  localparam int F_DA   = 3;
  localparam int F_DB   = 4;

  // command bits
  localparam int C_DIR   = 23;
  localparam int C_CLRIP = 3;
  localparam int C_AUX   = 2;

  // status and control word bits
  localparam int S_BUSY    = 7;
  localparam int K_NEWDAT  = 15;
  localparam int K_INTPND  = 13;
  localparam int K_TXREQ   = 8;

  function automatic logic [NFLD-1:0] field_sel(input logic [7:0] lo);
    return {lo[0], lo[1], lo[5], lo[6], lo[7]};
  endfunction
endpackage

// File: rtl/mif_seq.sv
module mif_seq #(
  parameter int ACC_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int CW = (ACC_CYCLES > 2) ? $clog2(ACC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACC_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !commit_o) |=> busy_q);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_q);
endmodule

// File: rtl/mif_objram.sv
module mif_objram
  import mif_pkg::*;
#(
  parameter int NOBJ = 64,
  parameter int DW   = 32,
  localparam int IDXW = $clog2(NOBJ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit_i,
  input  logic                      dir_wr_i,
  input  logic                      clr_ip_i,
  input  logic                      aux_i,
  input  logic [NFLD-1:0]           sel_i,
  input  logic [IDXW-1:0]           idx_i,
  input  logic [NFLD-1:0][DW-1:0]   stg_i,
  output logic [NFLD-1:0][DW-1:0]   rd_o,
  output logic [NOBJ-1:0]           irq_o
);
  logic [DW-1:0] ctrl_mem [NOBJ];
  logic [DW-1:0] ctrl_next;

  always_comb begin
    ctrl_next = (dir_wr_i && sel_i[F_CTRL]) ? stg_i[F_CTRL] : ctrl_mem[idx_i];
    if (dir_wr_i) begin
      if (aux_i) ctrl_next[K_TXREQ] = 1'b1;
    end else begin
      if (clr_ip_i) ctrl_next[K_INTPND] = 1'b0;
      if (aux_i)    ctrl_next[K_NEWDAT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NOBJ; k++) ctrl_mem[k] <= '0;
    end else if (commit_i) begin
      ctrl_mem[idx_i] <= ctrl_next;
    end
  end

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    if (f == F_CTRL) begin : g_ctrl
      assign rd_o[f] = ctrl_mem[idx_i];
    end else begin : g_plain
      logic [DW-1:0] mem [NOBJ];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < NOBJ; k++) mem[k] <= '0;
        end else if (commit_i && dir_wr_i && sel_i[f]) begin
          mem[idx_i] <= stg_i[f];
        end
      end
      assign rd_o[f] = mem[idx_i];
    end
  end

  for (genvar k = 0; k < NOBJ; k++) begin : g_irq
    assign irq_o[k] = ctrl_mem[k][K_INTPND];
  end

  // R6
  rd_clear_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !dir_wr_i && clr_ip_i) |=> !irq_o[$past(idx_i)]);

  // R7
  wr_keep_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && dir_wr_i && clr_ip_i && !sel_i[F_CTRL])
      |=> irq_o[$past(idx_i)] == $past(irq_o[idx_i]));

  // R9
  wr_txreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && dir_wr_i && aux_i) |=> ctrl_mem[$past(idx_i)][K_TXREQ]);
endmodule

// File: rtl/mif_regs.sv
module mif_regs
  import mif_pkg::*;
#(
  parameter int NOBJ = 64,
  parameter int DW   = 32,
  localparam int IDXW = $clog2(NOBJ),
  localparam int NUMW = $clog2(NOBJ + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [2:0]               bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic                     busy_i,
  input  logic                     commit_i,
  input  logic [NFLD-1:0][DW-1:0]  obj_rd_i,
  output logic                     start_o,
  output logic [NFLD-1:0][DW-1:0]  stg_o,
  output logic                     dir_wr_o,
  output logic                     clr_ip_o,
  output logic                     aux_o,
  output logic [NFLD-1:0]          sel_o,
  output logic [IDXW-1:0]          idx_o
);
  logic [DW-1:0]            cmd_q;
  logic [NUMW-1:0]          num_q;
  logic [NFLD-1:0][DW-1:0]  stg_q;
  logic                     wr_ok;
  logic                     num_ok;

  assign wr_ok   = bus_wr && !busy_i;
  assign num_ok  = (bus_wdata != '0) && (bus_wdata <= DW'(NOBJ));
  assign start_o = wr_ok && (bus_addr == A_NUM) && num_ok;

  assign stg_o    = stg_q;
  assign dir_wr_o = cmd_q[C_DIR];
  assign clr_ip_o = cmd_q[C_CLRIP];
  assign aux_o    = cmd_q[C_AUX];
  assign sel_o    = field_sel(cmd_q[7:0]);
  assign idx_o    = IDXW'(num_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      num_q <= '0;
    end else begin
      if (wr_ok && bus_addr == A_CMD) cmd_q <= bus_wdata;
      if (start_o)                    num_q <= NUMW'(bus_wdata);
    end
  end

  for (genvar f = 0; f < NFLD; f++) begin : g_stg
    localparam logic [2:0] FA = 3'(f + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[f] <= '0;
      end else if (wr_ok && bus_addr == FA) begin
        stg_q[f] <= bus_wdata;
      end else if (commit_i && !cmd_q[C_DIR] && sel_o[f]) begin
        stg_q[f] <= obj_rd_i[f];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CMD:  bus_rdata = cmd_q;
      A_MASK: bus_rdata = stg_q[F_MASK];
      A_ARB:  bus_rdata = stg_q[F_ARB];
      A_CTRL: bus_rdata = stg_q[F_CTRL];
      A_DA:   bus_rdata = stg_q[F_DA];
      A_DB:   bus_rdata = stg_q[F_DB];
      A_NUM:  bus_rdata = DW'(num_q);
      A_STAT: bus_rdata[S_BUSY] = busy_i;
      default: bus_rdata = '0;
    endcase
  end

  // R2
  num_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_NUM && !busy_i && bus_wdata != '0
     && bus_wdata <= DW'(NOBJ)) |=> busy_i);

  // R3
  bad_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_NUM && !busy_i
     && (bus_wdata == '0 || bus_wdata > DW'(NOBJ))) |=> (!busy_i && $stable(num_q)));

  // R10
  busy_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && bus_wr && !commit_i) |=> ($stable(stg_q) && $stable(cmd_q) && $stable(num_q)));
endmodule

// File: rtl/mif_xfer_unit.sv
module mif_xfer_unit
  import mif_pkg::*;
#(
  parameter int NOBJ       = 64,
  parameter int DW         = 32,
  parameter int ACC_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NOBJ-1:0] obj_irq
);
  localparam int IDXW = $clog2(NOBJ);

  logic                    start;
  logic                    busy;
  logic                    commit;
  logic                    dir_wr;
  logic                    clr_ip;
  logic                    aux;
  logic [NFLD-1:0]         sel;
  logic [IDXW-1:0]         idx;
  logic [NFLD-1:0][DW-1:0] stg;
  logic [NFLD-1:0][DW-1:0] obj_rd;

  mif_regs #(.NOBJ(NOBJ), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(busy), .commit_i(commit), .obj_rd_i(obj_rd),
    .start_o(start), .stg_o(stg), .dir_wr_o(dir_wr), .clr_ip_o(clr_ip),
    .aux_o(aux), .sel_o(sel), .idx_o(idx)
  );

  mif_seq #(.ACC_CYCLES(ACC_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .commit_o(commit)
  );

  mif_objram #(.NOBJ(NOBJ), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .dir_wr_i(dir_wr),
    .clr_ip_i(clr_ip), .aux_i(aux), .sel_i(sel), .idx_i(idx),
    .stg_i(stg), .rd_o(obj_rd), .irq_o(obj_irq)
  );
endmodule

// File: tb/mif_xfer_unit_tb.sv
module mif_xfer_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOBJ = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [2:0]      bus_addr = 3'd0;
  logic [31:0]     bus_wdata = 32'd0;
  logic [31:0]     bus_rdata;
  logic [NOBJ-1:0] obj_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mdl [0:NOBJ-1][0:4];
  logic [31:0] stg [0:4];
  logic [31:0] mcmd;

  always #(CLK_PERIOD/2) clk = ~clk;

  mif_xfer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .obj_irq(obj_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [4:0] sel_of(input logic [31:0] c);
    return {c[0], c[1], c[5], c[6], c[7]};
  endfunction

  function automatic logic [NOBJ-1:0] irq_exp();
    logic [NOBJ-1:0] v;
    for (int k = 0; k < NOBJ; k++) v[k] = mdl[k][2][13];
    return v;
  endfunction

  task automatic mdl_apply(input int num);
    logic [4:0] s;
    int i;
    s = sel_of(mcmd);
    i = num - 1;
    if (mcmd[23]) begin
      for (int f = 0; f < 5; f++) if (s[f]) mdl[i][f] = stg[f];
      if (mcmd[2]) mdl[i][2][8] = 1'b1;
    end else begin
      for (int f = 0; f < 5; f++) if (s[f]) stg[f] = mdl[i][f];
      if (mcmd[3]) mdl[i][2][13] = 1'b0;
      if (mcmd[2]) mdl[i][2][15] = 1'b0;
    end
  endtask

  task automatic set_stg(input int f, input logic [31:0] v);
    wr(3'(f + 1), v);
    stg[f] = v;
  endtask

  task automatic xfer(input int num, input logic [31:0] c, input string req);
    logic [31:0] d;
    wr(3'd0, c);
    mcmd = c;
    wr(3'd6, num);
    repeat (4) @(negedge clk);
    rd(3'd7, d);
    chk({req, " busy cleared"}, {63'd0, d[7]}, 64'd0);
    mdl_apply(num);
  endtask

  task automatic chk_all(input string req);
    logic [31:0] d;
    for (int f = 0; f < 5; f++) begin
      rd(3'(f + 1), d);
      chk(req, {32'd0, d}, {32'd0, stg[f]});
    end
    chk({req, " irq"}, obj_irq, irq_exp());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NOBJ; k++) for (int f = 0; f < 5; f++) mdl[k][f] = '0;
    for (int f = 0; f < 5; f++) stg[f] = '0;
    mcmd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset reg", {32'd0, d}, 64'd0);
    end
    chk("R1 reset irq", obj_irq, 64'd0);

    // R2 busy window, write of object 5 with all fields (R4)
    set_stg(0, 32'h1111_0000); set_stg(1, 32'h2222_0001);
    set_stg(2, 32'h0000_A0C3); set_stg(3, 32'hDA7A_0004); set_stg(4, 32'hDA7B_0005);
    wr(3'd0, 32'h0080_00E3); mcmd = 32'h0080_00E3;
    wr(3'd6, 32'd5);
    rd(3'd7, d); chk("R2 busy first", {63'd0, d[7]}, 64'd1);
    repeat (3) @(negedge clk);
    rd(3'd7, d); chk("R2 busy fourth", {63'd0, d[7]}, 64'd1);
    @(negedge clk);
    rd(3'd7, d); chk("R2 busy falls", {63'd0, d[7]}, 64'd0);
    mdl_apply(5);
    chk("R11 irq obj5", obj_irq, irq_exp());

    // R5 read back into cleared staging, only ctrl and data B selected
    for (int f = 0; f < 5; f++) set_stg(f, 32'h0);
    xfer(5, 32'h0000_0021, "R5");
    chk_all("R5 partial read");
    xfer(5, 32'h0000_00C2, "R5");
    chk_all("R5 rest read");

    // R3 invalid numbers
    wr(3'd6, 32'd0);
    rd(3'd7, d); chk("R3 num 0 idle", {63'd0, d[7]}, 64'd0);
    wr(3'd6, 32'd65);
    rd(3'd7, d); chk("R3 num 65 idle", {63'd0, d[7]}, 64'd0);
    rd(3'd6, d); chk("R3 num kept", {32'd0, d}, 64'd5);

    // R6 and R8: read with clear-pending and clear-new-data, ctrl selected gets old value
    xfer(5, 32'h0000_002C, "R6");
    chk("R6 staging ctrl pre-clear", {32'd0, stg[2]}, {32'd0, 32'h0000_A0C3});
    chk_all("R6 R8 after clear read");
    xfer(5, 32'h0000_0020, "R8");
    chk("R8 newdat cleared", {63'd0, stg[2][15]}, 64'd0);
    chk("R6 intpnd cleared", {63'd0, stg[2][13]}, 64'd0);

    // R7 write with clear-pending bit ignored; R9 transmit request set
    set_stg(2, 32'h0000_2000);
    xfer(NOBJ, 32'h0080_0020, "R2 obj 64");
    chk("R2 obj 64 irq", {63'd0, obj_irq[NOBJ-1]}, 64'd1);
    xfer(NOBJ, 32'h0080_0008, "R7");
    chk("R7 irq kept", {63'd0, obj_irq[NOBJ-1]}, 64'd1);
    xfer(NOBJ, 32'h0080_0004, "R9");
    xfer(NOBJ, 32'h0000_0020, "R9");
    chk("R9 txreq set", {63'd0, stg[2][8]}, 64'd1);
    chk_all("R9 R7 state");

    // R10 writes while busy are dropped
    set_stg(0, 32'hCAFE_0009);
    wr(3'd0, 32'h0080_0080); mcmd = 32'h0080_0080;
    wr(3'd6, 32'd9);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd6, 32'd10);
    @(negedge clk);
    rd(3'd7, d); chk("R10 done", {63'd0, d[7]}, 64'd0);
    mdl_apply(9);
    @(negedge clk);
    rd(3'd7, d); chk("R10 no second transfer", {63'd0, d[7]}, 64'd0);
    rd(3'd1, d); chk("R10 mask kept", {32'd0, d}, {32'd0, 32'hCAFE_0009});
    rd(3'd6, d); chk("R10 num kept", {32'd0, d}, 64'd9);

    // random transfers against model (R4 R5 R6 R7 R8 R9 R11)
    for (int it = 0; it < 400; it++) begin
      int num;
      logic [31:0] c;
      num = 1 + int'($urandom_range(NOBJ - 1));
      if ($urandom_range(3) == 0) set_stg($urandom_range(4), $urandom);
      c = {8'd0, 1'($urandom_range(1)), 15'd0, 8'($urandom)};
      xfer(num, c, "R4 R5 random");
      chk_all("R4 R5 R11 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule